// File: doc/BRIEF.md
# Timing-Error Detecting and Repairing Flip-Flop

This block replaces an ordinary register at the end of a critical path. A main edge-triggered register samples the data word on the rising edge of the main clock. A second clock, `clkLate`, is the main clock delayed by half a period. A shadow latch watches the same data word and freezes its value when the main clock falls. A word that is still changing after the rising edge therefore leaves the main register and the shadow latch holding different values. That difference is the sign of a late arrival.

On the next rising edge a control part compares the two values. It raises a registered error flag for one cycle when they disagree. Each instance has its own repair enable. When repair is enabled and a mismatch is seen, the main register loads the shadow value instead of the data input, so the late value replaces the stale one. When repair is disabled, the flag is still reported but the register samples its input as usual. Generating the delayed clock and stalling the surrounding pipeline are left to the surrounding logic.

Top module: `timing_err_ff`

## Requirements
- R1: On each rising edge of `clk`, with reset low and no repair taking place, `qOut` takes the value that `dIn` had at that edge.
- R2: The shadow latch follows `dIn` while `clkLate` is low and holds from the rising edge of `clkLate`. With `clkLate` lagging `clk` by half a period, the shadow value is `dIn` as it stood at the falling edge of `clk`.
- R3: If, at a rising edge of `clk`, the register value differs from the shadow value, `timingErr` is 1 from that edge until the next rising edge. Data that changes only while `clk` is low never raises `timingErr`.
- R4: `timingErr` returns to 0 at the first rising edge at which the register and shadow values agree.
- R5: With `repairEn` = 1, a mismatch at a rising edge makes the register load the shadow value instead of `dIn`.
- R6: With `repairEn` = 0, a mismatch is still flagged, but the register loads `dIn` as in R1.
- R7: While the synchronous, active-high `rst` is held over rising edges of both clocks, `qOut`, `timingErr` and the shadow state are 0.
- R8: A word that changes after the rising edge but returns to the sampled value before the falling edge causes no error and no repair.
- R9: A late change of any single bit of the word is enough to raise `timingErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; the register samples on its rising edge |
| clkLate | input | 1 | Copy of `clk` delayed by half a period; clocks the shadow latch |
| rst | input | 1 | Synchronous active-high reset |
| repairEn | input | 1 | Enables loading the shadow value on a mismatch |
| dIn | input | WIDTH | Data word from the critical path |
| qOut | output | WIDTH | Registered data word |
| timingErr | output | 1 | Registered late-arrival flag, valid for one cycle |

## Verification
The bench builds the block with its default `WIDTH` of 8. This lets a single flipped top bit (0x00 to 0x80) stand for the narrowest late event, and whole-byte patterns stand for the widest. The bench places data changes at fixed offsets inside each half period: just after the rising edge to model late data, and in the low phase to model data that arrives on time. This covers a late value that stays, a late value followed at once by a new on-time value, and a transient that settles back before the falling edge. The same sequences are run with repair on and off, so the two settings lead to different register values at the port.

// File: rtl/tef_pkg.sv
`timescale 1ns/1ps
package tef_pkg;

  // Strobes the control part hands to the datapath each main-clock cycle.
  typedef struct packed {
    logic mismatch;     // register and shadow disagree at this edge
    logic loadShadow;   // steer the recovery multiplexer to the shadow value
  } tefStrobe_t;

endpackage

// File: rtl/tef_datapath.sv
`timescale 1ns/1ps
module tef_datapath
  import tef_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clkLate,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  input  tefStrobe_t       ctrl,
  output logic [WIDTH-1:0] qMain,
  output logic [WIDTH-1:0] qHeld
);

  logic [WIDTH-1:0] shadowQ;
  logic [WIDTH-1:0] nextMain;

  // Shadow latch: open while the delayed clock is low, which spans the high
  // phase of the main clock; closes when the main clock falls.
  always_latch begin
    if (rst)
      shadowQ <= '0;
    else if (!clkLate)
      shadowQ <= dIn;
  end

  // Keeps the frozen shadow value stable across the next main rising edge,
  // where the latch reopens.
  always_ff @(posedge clkLate) begin
    if (rst)
      qHeld <= '0;
    else
      qHeld <= shadowQ;
  end

  // Recovery multiplexer in front of the main register.
  always_comb begin
    if (ctrl.loadShadow)
      nextMain = qHeld;
    else
      nextMain = dIn;
  end

  always_ff @(posedge clk) begin
    if (rst)
      qMain <= '0;
    else
      qMain <= nextMain;
  end

  // R5
  repair_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadShadow |=> (qMain == $past(qHeld)));

  // R6
  keep_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mismatch && !ctrl.loadShadow) |=> (qMain == $past(dIn)));

endmodule

// File: rtl/tef_control.sv
`timescale 1ns/1ps
module tef_control
  import tef_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             repairEn,
  input  logic [WIDTH-1:0] qMain,
  input  logic [WIDTH-1:0] qHeld,
  output tefStrobe_t       ctrl,
  output logic             errFlag
);

  logic [WIDTH-1:0] diffBits;

  assign diffBits        = qMain ^ qHeld;
  assign ctrl.mismatch   = |diffBits;
  assign ctrl.loadShadow = ctrl.mismatch & repairEn;

  always_ff @(posedge clk) begin
    if (rst)
      errFlag <= 1'b0;
    else
      errFlag <= ctrl.mismatch;
  end

  // R5
  load_needs_diff_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadShadow |-> (qMain != qHeld));

endmodule

// File: rtl/timing_err_ff.sv
`timescale 1ns/1ps
module timing_err_ff
  import tef_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clkLate,
  input  logic             rst,
  input  logic             repairEn,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut,
  output logic             timingErr
);

  tefStrobe_t       strobes;
  logic [WIDTH-1:0] mainVal;
  logic [WIDTH-1:0] heldVal;

  tef_datapath #(.WIDTH(WIDTH)) dpath (
    .clk     (clk),
    .clkLate (clkLate),
    .rst     (rst),
    .dIn     (dIn),
    .ctrl    (strobes),
    .qMain   (mainVal),
    .qHeld   (heldVal)
  );

  tef_control #(.WIDTH(WIDTH)) cpath (
    .clk      (clk),
    .rst      (rst),
    .repairEn (repairEn),
    .qMain    (mainVal),
    .qHeld    (heldVal),
    .ctrl     (strobes),
    .errFlag  (timingErr)
  );

  assign qOut = mainVal;

  // R3
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (mainVal != heldVal) |=> timingErr);

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mainVal == heldVal) |=> !timingErr);

endmodule

// File: tb/timing_err_ff_test.sv
`timescale 1ns/1ps
module timing_err_ff_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clkLate = 1'b1;
  logic         rst = 1'b1;
  logic         repairEn = 1'b0;
  logic [W-1:0] dIn = '0;
  logic [W-1:0] qOut;
  logic         timingErr;

  int checks = 0;
  int fails = 0;

  timing_err_ff #(.WIDTH(W)) uut (
    .clk(clk), .clkLate(clkLate), .rst(rst), .repairEn(repairEn),
    .dIn(dIn), .qOut(qOut), .timingErr(timingErr)
  );

  // 8 ns period; clkLate is clk shifted by 4 ns.
  always #4 begin
    clk = ~clk;
    clkLate = ~clkLate;
  end

  task automatic check(string req, logic [W-1:0] gotQ, logic [W-1:0] expQ,
                       logic gotE, logic expE);
    checks++;
    if (gotQ !== expQ || gotE !== expE) begin
      fails++;
      $display("FAIL %s: q=%h err=%b, expected q=%h err=%b", req, gotQ, gotE, expQ, expE);
    end
  endtask

  // Changes dIn in the low phase, before the next rising edge.
  task automatic driveOnTime(logic [W-1:0] v);
    @(posedge clk); #6 dIn = v;
  endtask

  task automatic afterRise();
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    rst = 1'b1; dIn = 8'hFF; repairEn = 1'b1;
    repeat (3) afterRise();
    check("R7 reset", qOut, 8'h00, timingErr, 1'b0);
    @(posedge clk); #6 rst = 1'b0; dIn = 8'h00;
    afterRise();
    check("R7 after release", qOut, 8'h00, timingErr, 1'b0);
    repairEn = 1'b0;
  endtask

  task automatic testOnTime();
    driveOnTime(8'h3C); afterRise();
    check("R1 on-time 3C", qOut, 8'h3C, timingErr, 1'b0);
    driveOnTime(8'hA5); afterRise();
    check("R1 on-time A5", qOut, 8'hA5, timingErr, 1'b0);
    driveOnTime(8'h5A); afterRise();
    check("R3 on-time change gives no error", qOut, 8'h5A, timingErr, 1'b0);
  endtask

  // Late B after the edge, on-time C for the next cycle.
  task automatic testLateThenNew(logic rep);
    repairEn = rep;
    driveOnTime(8'h11);
    @(posedge clk); #2 dIn = 8'h22; #4 dIn = 8'h33;
    afterRise();
    if (rep) check("R5 repair loads shadow", qOut, 8'h22, timingErr, 1'b1);
    else     check("R6 no repair keeps input", qOut, 8'h33, timingErr, 1'b1);
    afterRise();
    if (rep) check("R5 second repair", qOut, 8'h33, timingErr, 1'b1);
    else     check("R4 err clears", qOut, 8'h33, timingErr, 1'b0);
    if (rep) begin
      afterRise();
      check("R4 err clears after repair", qOut, 8'h33, timingErr, 1'b0);
    end
    repairEn = 1'b0;
  endtask

  task automatic testLateStays();
    repairEn = 1'b1;
    driveOnTime(8'h40);
    @(posedge clk); #2 dIn = 8'hC7;
    afterRise();
    check("R2 shadow holds late value", qOut, 8'hC7, timingErr, 1'b1);
    afterRise();
    check("R4 clears once stable", qOut, 8'hC7, timingErr, 1'b0);
    repairEn = 1'b0;
  endtask

  task automatic testSettleBack();
    repairEn = 1'b1;
    driveOnTime(8'h6E);
    @(posedge clk); #1 dIn = 8'h91; #2 dIn = 8'h6E;
    afterRise();
    check("R8 transient settles back", qOut, 8'h6E, timingErr, 1'b0);
    repairEn = 1'b0;
  endtask

  task automatic testSingleBit();
    driveOnTime(8'h00);
    @(posedge clk); #2 dIn = 8'h80;
    afterRise();
    check("R9 top bit late", qOut, 8'h80, timingErr, 1'b1);
    driveOnTime(8'h80);
    @(posedge clk); #2 dIn = 8'h81;
    afterRise();
    check("R9 low bit late", qOut, 8'h81, timingErr, 1'b1);
  endtask

  task automatic testResetDuringError();
    driveOnTime(8'h0F);
    @(posedge clk); #2 dIn = 8'hF0;
    afterRise();
    check("R3 late before reset", qOut, 8'hF0, timingErr, 1'b1);
    #1 rst = 1'b1;
    afterRise();
    check("R7 reset clears error", qOut, 8'h00, timingErr, 1'b0);
    afterRise();
    @(posedge clk); #6 rst = 1'b0; dIn = 8'h00;
    afterRise();
    check("R7 shadow cleared", qOut, 8'h00, timingErr, 1'b0);
  endtask

  initial begin
    testReset();
    testOnTime();
    testLateThenNew(1'b0);
    testLateThenNew(1'b1);
    testLateStays();
    testSettleBack();
    testSingleBit();
    testResetDuringError();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule